// File: doc/BRIEF.md
# Dual-Port Mailbox RAM

A symmetric two-port memory of 2048 nine-bit words. The left and right ports each carry an address, write data, read data, an active-low chip enable, an active-low write enable, an active-low output enable, an active-low busy input and an active-low interrupt output. Either port may read or write any word in any cycle. The block is a synchronous single-clock model: a read returns its word one clock after the request, and a data-valid flag takes the place of a three-state data bus.

The two highest words double as mailboxes between the ports. Word 0x7FF belongs to the right side: a left write there raises the right interrupt, and a right read of it clears that interrupt. Word 0x7FE belongs to the left side in the same way. The busy input comes from outside, from contention logic that is not part of this block. A low busy input blocks that port's writes and any interrupt change the port would cause.

Top module: `dpram_mailbox`

## Requirements
- R1: A port with chip enable low, write enable low and busy high stores its write data at its address. A read then returns that word on the port's data output one clock after the request.
- R2: A port with chip enable high stores nothing. One clock later its data-valid output is low and its data output is zero.
- R3: A write attempt made while that port's busy input is low leaves the addressed word unchanged.
- R4: A read needs chip enable low, write enable high and output enable low. With output enable high, data-valid is low one clock later and the data output is zero.
- R5: A left-port write to address 0x7FF drives the right interrupt output low from the next clock.
- R6: A right-port read at address 0x7FF, with busy high, drives the right interrupt output high from the next clock.
- R7: A right-port write to 0x7FE drives the left interrupt output low. A left-port read at 0x7FE with busy high drives it high.
- R8: While the busy input of the port that would set or clear an interrupt is low, that interrupt output keeps its value.
- R9: A synchronous active-high reset drives both interrupt outputs high and both data-valid outputs low.
- R10: When an interrupt is set and cleared in the same cycle, it ends up set (output low).
- R11: When one port reads a word that the other port writes in the same cycle, the reader gets the old contents.
- R12: When both ports write the same word in one cycle and neither is busy, the left port's data is kept.
- R13: The mailbox words keep written data like any other word and return it on a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous active-high reset |
| l_addr | input | 11 | Left word address |
| l_din | input | 9 | Left write data |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_we_n | input | 1 | Left write enable, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_busy_n | input | 1 | Left busy, active low |
| l_dout | output | 9 | Left read data, zero when not valid |
| l_dout_vld | output | 1 | Left read data valid |
| l_int_n | output | 1 | Left interrupt, active low |
| r_addr | input | 11 | Right word address |
| r_din | input | 9 | Right write data |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_we_n | input | 1 | Right write enable, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_busy_n | input | 1 | Right busy, active low |
| r_dout | output | 9 | Right read data, zero when not valid |
| r_dout_vld | output | 1 | Right read data valid |
| r_int_n | output | 1 | Right interrupt, active low |

## Verification
Directed sequences first try each access kind on one port while the other port is idle. This separates true storage from an echo of the input data, and separates a blocked write from a write that lands. Paired sequences then aim both ports at one word in the same cycle, which tells read-before-write from write-first ordering and shows which side wins a double write. Mailbox sequences set, clear and busy-block each interrupt, and set and clear one flag at once, to tell set priority from clear priority. A long random phase biased toward the two mailbox words and a few shared addresses is compared against a behavioural model on every clock.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
    // Decoded access of one port for one cycle
    typedef struct packed {
        logic wr;   // write that may land (busy already applied)
        logic rd;   // read request (busy not applied)
    } dpm_acc_s;

    typedef enum logic {
        SIDE_LEFT  = 1'b0,
        SIDE_RIGHT = 1'b1
    } dpm_side_e;
endpackage

// File: rtl/dpm_port_ctl.sv
module dpm_port_ctl
    import dpm_pkg::*;
(
    input  logic     ce_n,
    input  logic     we_n,
    input  logic     oe_n,
    input  logic     busy_n,
    output dpm_acc_s acc
);
    always_comb begin
        acc    = '0;
        acc.wr = ~ce_n & ~we_n & busy_n;
        acc.rd = ~ce_n &  we_n & ~oe_n;
    end
endmodule

// File: rtl/dpm_store.sv
module dpm_store #(
    parameter int AW = 11,
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          wr_l,
    input  logic [AW-1:0] addr_l,
    input  logic [DW-1:0] wdata_l,
    input  logic          wr_r,
    input  logic [AW-1:0] addr_r,
    input  logic [DW-1:0] wdata_r,
    output logic [DW-1:0] rdata_l,
    output logic [DW-1:0] rdata_r
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rdl_q, rdr_q;

    // Reads sample the array before this edge's writes: old data on a clash.
    // Right write first, left write second, so the left port wins a clash.
    always_ff @(posedge clk) begin
        rdl_q <= mem_q[addr_l];
        rdr_q <= mem_q[addr_r];
        if (wr_r) mem_q[addr_r] <= wdata_r;
        if (wr_l) mem_q[addr_l] <= wdata_l;
    end

    assign rdata_l = rdl_q;
    assign rdata_r = rdr_q;
endmodule

// File: rtl/dpm_mbox_flag.sv
module dpm_mbox_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    input  logic clr_busy_n,
    output logic irq_n
);
    typedef struct packed {
        logic flag;
    } flag_s;

    flag_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_req)
            st_d.flag = 1'b1;
        else if (clr_req && clr_busy_n)
            st_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign irq_n = ~st_q.flag;

    p_set_r5: assert property (@(posedge clk) disable iff (rst)
        set_req |=> !irq_n);
    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_req && clr_busy_n && !set_req) |=> irq_n);
    p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !clr_busy_n && !set_req) |=> $stable(irq_n));
    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (set_req && clr_req) |=> !irq_n);
endmodule

// File: rtl/dpram_mailbox.sv
module dpram_mailbox
    import dpm_pkg::*;
#(
    parameter int AW = 11,
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_din,
    input  logic          l_ce_n,
    input  logic          l_we_n,
    input  logic          l_oe_n,
    input  logic          l_busy_n,
    output logic [DW-1:0] l_dout,
    output logic          l_dout_vld,
    output logic          l_int_n,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_din,
    input  logic          r_ce_n,
    input  logic          r_we_n,
    input  logic          r_oe_n,
    input  logic          r_busy_n,
    output logic [DW-1:0] r_dout,
    output logic          r_dout_vld,
    output logic          r_int_n
);
    localparam int NPORT = 2;
    // Mailbox of each side: the word whose read clears that side's interrupt
    localparam logic [AW-1:0] MBOX_LEFT  = {{(AW-1){1'b1}}, 1'b0};
    localparam logic [AW-1:0] MBOX_RIGHT = {AW{1'b1}};

    logic [NPORT-1:0] ce_n_v, we_n_v, oe_n_v, busy_n_v, irq_n_v;
    logic [AW-1:0]    addr_v [NPORT];
    dpm_acc_s         acc    [NPORT];
    logic [DW-1:0]    rdata_l, rdata_r;

    assign ce_n_v   = {r_ce_n, l_ce_n};
    assign we_n_v   = {r_we_n, l_we_n};
    assign oe_n_v   = {r_oe_n, l_oe_n};
    assign busy_n_v = {r_busy_n, l_busy_n};
    assign addr_v[SIDE_LEFT]  = l_addr;
    assign addr_v[SIDE_RIGHT] = r_addr;

    for (genvar s = 0; s < NPORT; s++) begin : g_port
        localparam logic [AW-1:0] MB = (s == 0) ? MBOX_LEFT : MBOX_RIGHT;
        logic set_req, clr_req;

        dpm_port_ctl u_ctl (
            .ce_n   (ce_n_v[s]),
            .we_n   (we_n_v[s]),
            .oe_n   (oe_n_v[s]),
            .busy_n (busy_n_v[s]),
            .acc    (acc[s])
        );

        // The opposite side writes this side's mailbox; this side reads it
        assign set_req = acc[NPORT-1-s].wr && (addr_v[NPORT-1-s] == MB);
        assign clr_req = acc[s].rd && (addr_v[s] == MB);

        dpm_mbox_flag u_flag (
            .clk        (clk),
            .rst        (rst),
            .set_req    (set_req),
            .clr_req    (clr_req),
            .clr_busy_n (busy_n_v[s]),
            .irq_n      (irq_n_v[s])
        );
    end

    dpm_store #(.AW(AW), .DW(DW)) u_store (
        .clk     (clk),
        .wr_l    (acc[SIDE_LEFT].wr),
        .addr_l  (l_addr),
        .wdata_l (l_din),
        .wr_r    (acc[SIDE_RIGHT].wr),
        .addr_r  (r_addr),
        .wdata_r (r_din),
        .rdata_l (rdata_l),
        .rdata_r (rdata_r)
    );

    typedef struct packed {
        logic [NPORT-1:0] vld;
    } out_s;

    out_s out_d, out_q;

    always_comb begin
        out_d     = out_q;
        out_d.vld = {acc[SIDE_RIGHT].rd, acc[SIDE_LEFT].rd};
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign l_dout_vld = out_q.vld[SIDE_LEFT];
    assign r_dout_vld = out_q.vld[SIDE_RIGHT];
    assign l_dout     = out_q.vld[SIDE_LEFT]  ? rdata_l : '0;
    assign r_dout     = out_q.vld[SIDE_RIGHT] ? rdata_r : '0;
    assign l_int_n    = irq_n_v[SIDE_LEFT];
    assign r_int_n    = irq_n_v[SIDE_RIGHT];

    p_idle_left_r2: assert property (@(posedge clk) disable iff (rst)
        l_ce_n |=> (!l_dout_vld && l_dout == '0));
    p_idle_right_r2: assert property (@(posedge clk) disable iff (rst)
        r_ce_n |=> (!r_dout_vld && r_dout == '0));
    p_no_oe_left_r4: assert property (@(posedge clk) disable iff (rst)
        l_oe_n |=> !l_dout_vld);
    p_no_oe_right_r4: assert property (@(posedge clk) disable iff (rst)
        r_oe_n |=> !r_dout_vld);
    p_left_mbox_r7: assert property (@(posedge clk) disable iff (rst)
        (!r_ce_n && !r_we_n && r_busy_n && r_addr == MBOX_LEFT) |=> !l_int_n);
    p_right_mbox_r5: assert property (@(posedge clk) disable iff (rst)
        (!l_ce_n && !l_we_n && l_busy_n && l_addr == MBOX_RIGHT) |=> !r_int_n);
endmodule

// File: tb/tb_dpram_mailbox.sv
module tb_dpram_mailbox;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 11;
    localparam int DW = 9;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst;
    logic [AW-1:0] l_addr, r_addr;
    logic [DW-1:0] l_din, r_din, l_dout, r_dout;
    logic l_ce_n, l_we_n, l_oe_n, l_busy_n, l_dout_vld, l_int_n;
    logic r_ce_n, r_we_n, r_oe_n, r_busy_n, r_dout_vld, r_int_n;

    dpram_mailbox #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst(rst),
        .l_addr(l_addr), .l_din(l_din), .l_ce_n(l_ce_n), .l_we_n(l_we_n),
        .l_oe_n(l_oe_n), .l_busy_n(l_busy_n), .l_dout(l_dout),
        .l_dout_vld(l_dout_vld), .l_int_n(l_int_n),
        .r_addr(r_addr), .r_din(r_din), .r_ce_n(r_ce_n), .r_we_n(r_we_n),
        .r_oe_n(r_oe_n), .r_busy_n(r_busy_n), .r_dout(r_dout),
        .r_dout_vld(r_dout_vld), .r_int_n(r_int_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference: -1 marks a word never written
    int    m_mem [DEPTH];
    int    exp_lv, exp_rv, exp_ld, exp_rd, exp_lf, exp_rf;
    int    total = 0;
    int    bad = 0;
    string tag = "R9";

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model();
        bit lw, rw, lr, rr;
        if (rst) begin
            exp_lv = 0; exp_rv = 0; exp_ld = 0; exp_rd = 0;
            exp_lf = 0; exp_rf = 0;
            return;
        end
        lw = !l_ce_n && !l_we_n && l_busy_n;
        rw = !r_ce_n && !r_we_n && r_busy_n;
        lr = !l_ce_n && l_we_n && !l_oe_n;
        rr = !r_ce_n && r_we_n && !r_oe_n;
        exp_lv = lr; exp_rv = rr;
        exp_ld = lr ? m_mem[int'(l_addr)] : 0;
        exp_rd = rr ? m_mem[int'(r_addr)] : 0;
        if (lw && l_addr == 11'h7FF)                      exp_rf = 1;
        else if (rr && r_addr == 11'h7FF && r_busy_n)     exp_rf = 0;
        if (rw && r_addr == 11'h7FE)                      exp_lf = 1;
        else if (lr && l_addr == 11'h7FE && l_busy_n)     exp_lf = 0;
        if (rw) m_mem[int'(r_addr)] = int'(r_din);
        if (lw) m_mem[int'(l_addr)] = int'(l_din);
    endtask

    task automatic step();
        @(posedge clk);
        model();
        @(negedge clk);
        chk("l_dout_vld", {31'd0, l_dout_vld}, exp_lv);
        chk("r_dout_vld", {31'd0, r_dout_vld}, exp_rv);
        if (exp_ld >= 0) chk("l_dout", {23'd0, l_dout}, exp_ld);
        if (exp_rd >= 0) chk("r_dout", {23'd0, r_dout}, exp_rd);
        chk("l_int_n", {31'd0, l_int_n}, 1 - exp_lf);
        chk("r_int_n", {31'd0, r_int_n}, 1 - exp_rf);
    endtask

    task automatic setl(bit ce, bit we, bit oe, bit busy, int a, int d);
        l_ce_n = ce; l_we_n = we; l_oe_n = oe; l_busy_n = busy;
        l_addr = AW'(a); l_din = DW'(d);
    endtask

    task automatic setr(bit ce, bit we, bit oe, bit busy, int a, int d);
        r_ce_n = ce; r_we_n = we; r_oe_n = oe; r_busy_n = busy;
        r_addr = AW'(a); r_din = DW'(d);
    endtask

    task automatic idle();
        setl(1, 1, 1, 1, 0, 0);
        setr(1, 1, 1, 1, 0, 0);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = -1;
        rst = 1'b1;
        idle();
        repeat (3) step();
        rst = 1'b0;
        tag = "R9"; step();

        tag = "R1"; setl(0, 0, 1, 1, 5, 9'h1A5); step();
        idle(); setr(0, 1, 0, 1, 5, 0); step();
        idle(); step();

        tag = "R2"; setl(1, 0, 0, 1, 5, 9'h0F0); step();
        idle(); setr(0, 1, 0, 1, 5, 0); step();

        tag = "R3"; idle(); setl(0, 0, 1, 0, 5, 9'h007); step();
        idle(); setl(0, 1, 0, 1, 5, 0); step();

        tag = "R4"; idle(); setl(0, 1, 1, 1, 5, 0); step();

        tag = "R5"; idle(); setl(0, 0, 1, 1, 2047, 9'h055); step();
        tag = "R8"; idle(); setr(0, 1, 0, 0, 2047, 0); step();
        tag = "R6"; idle(); setr(0, 1, 0, 1, 2047, 0); step();
        tag = "R13"; idle(); setr(0, 1, 0, 1, 2047, 0); step();

        tag = "R7"; idle(); setr(0, 0, 1, 1, 2046, 9'h033); step();
        idle(); setl(0, 1, 0, 1, 2046, 0); step();

        tag = "R8"; idle(); setl(0, 0, 1, 0, 2047, 9'h1FF); step();
        idle(); setr(0, 0, 1, 0, 2046, 9'h1FF); step();

        tag = "R10"; idle(); setl(0, 0, 1, 1, 2047, 9'h011); step();
        setl(0, 0, 1, 1, 2047, 9'h012); setr(0, 1, 0, 1, 2047, 0); step();
        idle(); setr(0, 1, 0, 1, 2047, 0); step();

        tag = "R11"; idle(); setl(0, 0, 1, 1, 10, 1); step();
        setl(0, 0, 1, 1, 10, 2); setr(0, 1, 0, 1, 10, 0); step();
        idle(); setr(0, 1, 0, 1, 10, 0); step();

        tag = "R12"; setl(0, 0, 1, 1, 20, 9'h0AA); setr(0, 0, 1, 1, 20, 9'h155); step();
        idle(); setl(0, 1, 0, 1, 20, 0); step();

        tag = "random";
        for (int n = 0; n < 4000; n++) begin
            int pool [6];
            pool = '{2046, 2047, 0, 20, 10, int'($urandom % DEPTH)};
            setl($urandom % 4 == 0, $urandom % 2, $urandom % 3 == 0, $urandom % 5 != 0,
                 pool[$urandom % 6], int'($urandom % 512));
            setr($urandom % 4 == 0, $urandom % 2, $urandom % 3 == 0, $urandom % 5 != 0,
                 pool[$urandom % 6], int'($urandom % 512));
            step();
        end

        idle(); step();
        summary();
        $finish;
    end
endmodule